// File: doc/BRIEF.md
# Vector Register Scratchpad with Length and Stride Control

This block is a software-managed staging buffer arranged as a bank of vector registers whose elements are 64-bit words. It has no arithmetic: values enter and leave it only as whole words. A core moves single elements between the buffer and its own scalar registers over an element port, addressed by register number and element index. A memory transfer engine fills or drains registers over a separate bulk port.

A small control-register port exposes three values: a read-only maximum length, fixed to the physical register length; a writable active length that bounds the element port; and a stride word used by strided transfers. Software learns the physical register length by reading the maximum. It then writes the active length it wants, and any request above the maximum is clamped to it. The element port refuses indices at or beyond the active length. Such a read returns zero, such a write is dropped, and an error flag is raised in both cases. The bulk port is not limited by the active length, because the transfer engine sequences its own element count.

Register length and register count are parameters. The defaults are 32 registers of 64 elements, which is 16 KB. Physical lengths from 16 to 256 words are intended, and the length must be a power of two.

Top module: `vscratch_buf`

## Requirements
- R1: After reset the active length reads as the physical length, the stride reads as 1, and sc_rvalid, sc_err, bk_rvalid and cr_rvalid are all low.
- R2: Control selector 0 is the maximum length. A read of it returns the physical register length, and a write to it changes neither that value nor the active length.
- R3: A write of value v to control selector 1 (active length) stores min(v, physical length) over the full 64-bit value. A write of zero is accepted and reads back as 0.
- R4: An element-port read with index below the active length returns the addressed word one cycle later, with sc_rvalid high and sc_err low. An element-port write with such an index stores the word.
- R5: An element-port access with index at or beyond the active length raises sc_err for one cycle on the following cycle. On a read, sc_rdata is zero. On a write, the stored element is left unchanged.
- R6: Control selector 2 (stride) stores and returns all 64 bits of the written value, and it changes only when that selector is written.
- R7: The bulk port writes any element of any register, and reads return the word one cycle later with bk_rvalid high, whatever the active length.
- R8: When the element port and the bulk port write the same element in the same cycle, the bulk word is the one kept. Writes to different elements in the same cycle both take effect.
- R9: Control selector 3 is unused: a write to it changes no control register, and a read of it returns zero.
- R10: Control reads return their value one cycle after the request, with cr_rvalid high for that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sc_req | input | 1 | Element-port request |
| sc_we | input | 1 | Element-port write (1) or read (0) |
| sc_reg | input | $clog2(NUM_REGS) | Element-port register number |
| sc_idx | input | $clog2(REG_LEN) | Element-port element index |
| sc_wdata | input | 64 | Element-port write word |
| sc_rdata | output | 64 | Element-port read word, zero when refused |
| sc_rvalid | output | 1 | Element-port read response valid |
| sc_err | output | 1 | Element-port index out of active range |
| bk_we | input | 1 | Bulk-port write strobe |
| bk_re | input | 1 | Bulk-port read strobe |
| bk_reg | input | $clog2(NUM_REGS) | Bulk-port register number |
| bk_idx | input | $clog2(REG_LEN) | Bulk-port element index |
| bk_wdata | input | 64 | Bulk-port write word |
| bk_rdata | output | 64 | Bulk-port read word |
| bk_rvalid | output | 1 | Bulk-port read response valid |
| cr_wr | input | 1 | Control-register write strobe |
| cr_rd | input | 1 | Control-register read strobe |
| cr_sel | input | 2 | Control selector: 0 max length, 1 active length, 2 stride, 3 unused |
| cr_wdata | input | 64 | Control-register write value |
| cr_rdata | output | 64 | Control-register read value |
| cr_rvalid | output | 1 | Control-register read response valid |

## Verification
The bench builds the buffer with 4 registers of 16 elements. At that size every element of the array can be filled over the bulk port and read back over the element port, and then the reverse, in a few hundred cycles. Every active length from 0 up past the maximum can be written and read back. For a chosen set of active lengths (0, 1, 7, 15 and 16), the element port is swept across all 16 indices, so that the boundary between accepted and refused accesses is hit from both sides. Same-cycle collisions between the two write ports, and accesses to the unused selector, are then checked against a shadow copy of the array kept in the bench.

// File: rtl/vsb_pkg.sv
package vsb_pkg;
    localparam int unsigned ELEM_W = 64;

    typedef enum logic [1:0] {
        CR_MAXLEN = 2'd0,
        CR_ACTLEN = 2'd1,
        CR_STRIDE = 2'd2,
        CR_SPARE  = 2'd3
    } cr_sel_e;
endpackage

// File: rtl/vsb_ctrl_regs.sv
module vsb_ctrl_regs
    import vsb_pkg::*;
#(
    parameter int unsigned REG_LEN = 64,
    localparam int unsigned LW = $clog2(REG_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic              rd,
    input  logic [1:0]        sel,
    input  logic [ELEM_W-1:0] wdata,
    output logic [ELEM_W-1:0] rdata,
    output logic              rvalid,
    output logic [LW-1:0]     act_len,
    output logic [ELEM_W-1:0] stride
);
    localparam logic [ELEM_W-1:0] MAXV = ELEM_W'(REG_LEN);

    typedef struct packed {
        logic [LW-1:0]     vl;
        logic [ELEM_W-1:0] stride;
        logic [ELEM_W-1:0] rdata;
        logic              rvalid;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.rvalid = rd;
        st_d.rdata  = '0;
        if (rd) begin
            case (cr_sel_e'(sel))
                CR_MAXLEN: st_d.rdata = MAXV;
                CR_ACTLEN: st_d.rdata = ELEM_W'(st_q.vl);
                CR_STRIDE: st_d.rdata = st_q.stride;
                default:   st_d.rdata = '0;
            endcase
        end
        if (wr) begin
            case (cr_sel_e'(sel))
                CR_ACTLEN: st_d.vl = (wdata > MAXV) ? LW'(REG_LEN) : wdata[LW-1:0];
                CR_STRIDE: st_d.stride = wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.vl     <= LW'(REG_LEN);
            st_q.stride <= ELEM_W'(1);
            st_q.rdata  <= '0;
            st_q.rvalid <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata   = st_q.rdata;
    assign rvalid  = st_q.rvalid;
    assign act_len = st_q.vl;
    assign stride  = st_q.stride;
endmodule

// File: rtl/vsb_elem_port.sv
module vsb_elem_port
    import vsb_pkg::*;
#(
    parameter int unsigned IW = 6,
    parameter int unsigned LW = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [IW-1:0]     idx,
    input  logic [LW-1:0]     act_len,
    input  logic [ELEM_W-1:0] raw_rdata,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ELEM_W-1:0] rdata,
    output logic              rvalid,
    output logic              err
);
    typedef struct packed {
        logic rvalid;
        logic err;
        logic pass;
    } resp_t;

    resp_t st_d, st_q;
    logic  in_rng;

    always_comb begin
        in_rng      = LW'(idx) < act_len;
        mem_we      = req && we && in_rng;
        mem_re      = req && !we && in_rng;
        st_d.rvalid = req && !we;
        st_d.err    = req && !in_rng;
        st_d.pass   = mem_re;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata  = st_q.pass ? raw_rdata : '0;
    assign rvalid = st_q.rvalid;
    assign err    = st_q.err;
endmodule

// File: rtl/vsb_store.sv
module vsb_store
    import vsb_pkg::*;
#(
    parameter int unsigned DEPTH = 2048,
    localparam int unsigned AW = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_we,
    input  logic              s_re,
    input  logic [AW-1:0]     s_addr,
    input  logic [ELEM_W-1:0] s_wdata,
    output logic [ELEM_W-1:0] s_rdata,
    input  logic              b_we,
    input  logic              b_re,
    input  logic [AW-1:0]     b_addr,
    input  logic [ELEM_W-1:0] b_wdata,
    output logic [ELEM_W-1:0] b_rdata,
    output logic              b_rvalid
);
    logic [ELEM_W-1:0] mem [DEPTH];
    logic [ELEM_W-1:0] s_rdata_q, b_rdata_q;
    logic              b_rvalid_q;

    // The bulk write is issued after the element write, so it wins on a shared address.
    always_ff @(posedge clk) begin
        if (s_we) mem[s_addr] <= s_wdata;
        if (b_we) mem[b_addr] <= b_wdata;
        if (s_re) s_rdata_q   <= mem[s_addr];
        if (b_re) b_rdata_q   <= mem[b_addr];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) b_rvalid_q <= 1'b0;
        else        b_rvalid_q <= b_re;
    end

    assign s_rdata  = s_rdata_q;
    assign b_rdata  = b_rdata_q;
    assign b_rvalid = b_rvalid_q;
endmodule

// File: rtl/vscratch_buf.sv
module vscratch_buf
    import vsb_pkg::*;
#(
    parameter int unsigned NUM_REGS = 32,
    parameter int unsigned REG_LEN  = 64,
    localparam int unsigned RW = $clog2(NUM_REGS),
    localparam int unsigned IW = $clog2(REG_LEN),
    localparam int unsigned LW = $clog2(REG_LEN + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sc_req,
    input  logic              sc_we,
    input  logic [RW-1:0]     sc_reg,
    input  logic [IW-1:0]     sc_idx,
    input  logic [ELEM_W-1:0] sc_wdata,
    output logic [ELEM_W-1:0] sc_rdata,
    output logic              sc_rvalid,
    output logic              sc_err,
    input  logic              bk_we,
    input  logic              bk_re,
    input  logic [RW-1:0]     bk_reg,
    input  logic [IW-1:0]     bk_idx,
    input  logic [ELEM_W-1:0] bk_wdata,
    output logic [ELEM_W-1:0] bk_rdata,
    output logic              bk_rvalid,
    input  logic              cr_wr,
    input  logic              cr_rd,
    input  logic [1:0]        cr_sel,
    input  logic [ELEM_W-1:0] cr_wdata,
    output logic [ELEM_W-1:0] cr_rdata,
    output logic              cr_rvalid
);
    localparam int unsigned DEPTH = NUM_REGS * REG_LEN;

    logic [LW-1:0]     act_len;
    logic [ELEM_W-1:0] stride_val;
    logic              el_we, el_re;
    logic [ELEM_W-1:0] el_raw;

    vsb_ctrl_regs #(.REG_LEN(REG_LEN)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cr_wr),
        .rd      (cr_rd),
        .sel     (cr_sel),
        .wdata   (cr_wdata),
        .rdata   (cr_rdata),
        .rvalid  (cr_rvalid),
        .act_len (act_len),
        .stride  (stride_val)
    );

    vsb_elem_port #(.IW(IW), .LW(LW)) u_elem (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (sc_req),
        .we        (sc_we),
        .idx       (sc_idx),
        .act_len   (act_len),
        .raw_rdata (el_raw),
        .mem_we    (el_we),
        .mem_re    (el_re),
        .rdata     (sc_rdata),
        .rvalid    (sc_rvalid),
        .err       (sc_err)
    );

    vsb_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .s_we     (el_we),
        .s_re     (el_re),
        .s_addr   ({sc_reg, sc_idx}),
        .s_wdata  (sc_wdata),
        .s_rdata  (el_raw),
        .b_we     (bk_we),
        .b_re     (bk_re),
        .b_addr   ({bk_reg, bk_idx}),
        .b_wdata  (bk_wdata),
        .b_rdata  (bk_rdata),
        .b_rvalid (bk_rvalid)
    );
endmodule

// File: rtl/vsb_checker.sv
module vsb_checker
    import vsb_pkg::*;
#(
    parameter int unsigned REG_LEN = 64,
    parameter int unsigned IW = 6,
    parameter int unsigned LW = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_req,
    input logic              sc_we,
    input logic [IW-1:0]     sc_idx,
    input logic [ELEM_W-1:0] sc_rdata,
    input logic              sc_rvalid,
    input logic              sc_err,
    input logic              cr_wr,
    input logic              cr_rd,
    input logic [1:0]        cr_sel,
    input logic [ELEM_W-1:0] cr_wdata,
    input logic [ELEM_W-1:0] cr_rdata,
    input logic              cr_rvalid,
    input logic [LW-1:0]     act_len,
    input logic [ELEM_W-1:0] stride_val
);
    // R2
    maxlen_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd && cr_sel == 2'd0 |=> cr_rdata == ELEM_W'(REG_LEN));

    // R3
    actlen_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_wr && cr_sel == 2'd1 && cr_wdata > ELEM_W'(REG_LEN) |=> act_len == LW'(REG_LEN));

    // R5
    oob_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && LW'(sc_idx) >= act_len |=> sc_err && sc_rdata == '0);

    // R4
    inrange_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && LW'(sc_idx) < act_len |=> !sc_err);

    // R4
    elem_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sc_req && !sc_we |=> sc_rvalid);

    // R6
    stride_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cr_wr && cr_sel == 2'd2) |=> $stable(stride_val));

    // R10
    ctrl_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cr_rd |=> cr_rvalid);
endmodule

bind vscratch_buf vsb_checker #(.REG_LEN(REG_LEN), .IW(IW), .LW(LW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sc_req     (sc_req),
    .sc_we      (sc_we),
    .sc_idx     (sc_idx),
    .sc_rdata   (sc_rdata),
    .sc_rvalid  (sc_rvalid),
    .sc_err     (sc_err),
    .cr_wr      (cr_wr),
    .cr_rd      (cr_rd),
    .cr_sel     (cr_sel),
    .cr_wdata   (cr_wdata),
    .cr_rdata   (cr_rdata),
    .cr_rvalid  (cr_rvalid),
    .act_len    (act_len),
    .stride_val (stride_val)
);

// File: tb/vscratch_buf_bench.sv
`timescale 1ns/1ps
module vscratch_buf_bench;
    localparam int NR = 4;
    localparam int RL = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sc_req = 0, sc_we = 0;
    logic [1:0]  sc_reg = 0;
    logic [3:0]  sc_idx = 0;
    logic [63:0] sc_wdata = 0;
    logic [63:0] sc_rdata;
    logic        sc_rvalid, sc_err;
    logic        bk_we = 0, bk_re = 0;
    logic [1:0]  bk_reg = 0;
    logic [3:0]  bk_idx = 0;
    logic [63:0] bk_wdata = 0;
    logic [63:0] bk_rdata;
    logic        bk_rvalid;
    logic        cr_wr = 0, cr_rd = 0;
    logic [1:0]  cr_sel = 0;
    logic [63:0] cr_wdata = 0;
    logic [63:0] cr_rdata;
    logic        cr_rvalid;

    int total = 0;
    int bad = 0;
    logic [63:0] model [NR][RL];
    logic [63:0] rd_v;

    always #4 clk = ~clk;

    vscratch_buf #(.NUM_REGS(NR), .REG_LEN(RL)) u_vscratch_buf (.*);

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    function automatic logic [63:0] pat(input int r, input int i, input int salt);
        return {32'(r * 1000 + salt), 32'(i * 7 + 3)} ^ 64'hA5A5_0F0F_3C3C_9696;
    endfunction

    task automatic cr_write(input logic [1:0] s, input logic [63:0] d);
        cr_wr = 1; cr_sel = s; cr_wdata = d;
        @(negedge clk);
        cr_wr = 0;
    endtask

    task automatic cr_read(input logic [1:0] s, output logic [63:0] d, input string rq);
        cr_rd = 1; cr_sel = s;
        @(negedge clk);
        cr_rd = 0;
        chk(rq, 64'(cr_rvalid), 64'd1);
        d = cr_rdata;
    endtask

    task automatic bk_write(input int r, input int i, input logic [63:0] d);
        bk_we = 1; bk_reg = 2'(r); bk_idx = 4'(i); bk_wdata = d;
        @(negedge clk);
        bk_we = 0;
    endtask

    task automatic bk_read(input int r, input int i, output logic [63:0] d, input string rq);
        bk_re = 1; bk_reg = 2'(r); bk_idx = 4'(i);
        @(negedge clk);
        bk_re = 0;
        chk(rq, 64'(bk_rvalid), 64'd1);
        d = bk_rdata;
    endtask

    task automatic sc_access(input logic w, input int r, input int i, input logic [63:0] d);
        sc_req = 1; sc_we = w; sc_reg = 2'(r); sc_idx = 4'(i); sc_wdata = d;
        @(negedge clk);
        sc_req = 0; sc_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", total, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1: reset state
        chk("R1 sc_rvalid", 64'(sc_rvalid), 0);
        chk("R1 sc_err", 64'(sc_err), 0);
        chk("R1 bk_rvalid", 64'(bk_rvalid), 0);
        chk("R1 cr_rvalid", 64'(cr_rvalid), 0);
        cr_read(2'd1, rd_v, "R1"); chk("R1 actlen", rd_v, 64'(RL));
        cr_read(2'd2, rd_v, "R1"); chk("R1 stride", rd_v, 64'd1);
        @(negedge clk);
        chk("R10 single pulse", 64'(cr_rvalid), 0);

        // R2: maximum length fixed
        cr_read(2'd0, rd_v, "R2"); chk("R2 maxlen", rd_v, 64'(RL));
        cr_write(2'd0, 64'd5);
        cr_read(2'd0, rd_v, "R2"); chk("R2 maxlen after write", rd_v, 64'(RL));
        cr_read(2'd1, rd_v, "R2"); chk("R2 actlen untouched", rd_v, 64'(RL));

        // R7: bulk fill and readback over every element
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < RL; i++) begin
                model[r][i] = pat(r, i, 1);
                bk_write(r, i, model[r][i]);
            end
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < RL; i++) begin
                bk_read(r, i, rd_v, "R7");
                chk("R7 bulk readback", rd_v, model[r][i]);
            end

        // R4: element-port reads of every element, then element writes read back in bulk
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < RL; i++) begin
                sc_access(0, r, i, 0);
                chk("R4 rvalid", 64'(sc_rvalid), 1);
                chk("R4 err", 64'(sc_err), 0);
                chk("R4 rdata", sc_rdata, model[r][i]);
            end
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < RL; i++) begin
                model[r][i] = pat(r, i, 2);
                sc_access(1, r, i, model[r][i]);
                chk("R4 write err", 64'(sc_err), 0);
            end
        for (int r = 0; r < NR; r++)
            for (int i = 0; i < RL; i++) begin
                bk_read(r, i, rd_v, "R4");
                chk("R4 element write stored", rd_v, model[r][i]);
            end

        // R3: active-length sweep with clamping, plus a huge value
        for (int v = 0; v <= RL + 4; v++) begin
            cr_write(2'd1, 64'(v));
            cr_read(2'd1, rd_v, "R3");
            chk("R3 actlen", rd_v, 64'((v > RL) ? RL : v));
        end
        cr_write(2'd1, 64'hFFFF_FFFF_FFFF_FFF0);
        cr_read(2'd1, rd_v, "R3"); chk("R3 huge clamp", rd_v, 64'(RL));
        cr_write(2'd1, 64'h1_0000_0003);
        cr_read(2'd1, rd_v, "R3"); chk("R3 upper bits clamp", rd_v, 64'(RL));

        // R5: boundary sweeps of element reads across several active lengths
        foreach (model[0][k]) begin end
        for (int t = 0; t < 5; t++) begin
            int v;
            v = (t == 0) ? 0 : (t == 1) ? 1 : (t == 2) ? 7 : (t == 3) ? 15 : 16;
            cr_write(2'd1, 64'(v));
            for (int i = 0; i < RL; i++) begin
                sc_access(0, 2, i, 0);
                chk("R5 err", 64'(sc_err), 64'(i >= v));
                chk("R5 rdata", sc_rdata, (i >= v) ? 64'd0 : model[2][i]);
            end
        end
        cr_write(2'd1, 64'd4);
        sc_access(1, 1, 10, 64'hDEAD_DEAD_DEAD_DEAD);
        chk("R5 write err", 64'(sc_err), 1);
        @(negedge clk);
        chk("R5 err one cycle", 64'(sc_err), 0);
        bk_read(1, 10, rd_v, "R5");
        chk("R5 refused write left element", rd_v, model[1][10]);
        // R7: bulk ignores the active length
        bk_read(3, 12, rd_v, "R7"); chk("R7 beyond actlen", rd_v, model[3][12]);
        model[3][13] = 64'h1357_9BDF_2468_ACE0;
        bk_write(3, 13, model[3][13]);
        bk_read(3, 13, rd_v, "R7"); chk("R7 write beyond actlen", rd_v, model[3][13]);

        // R6: stride full width
        cr_write(2'd2, 64'hDEAD_BEEF_0123_4567);
        cr_read(2'd2, rd_v, "R6"); chk("R6 stride", rd_v, 64'hDEAD_BEEF_0123_4567);
        cr_write(2'd2, 64'hFFFF_FFFF_FFFF_FFFD);
        cr_read(2'd2, rd_v, "R6"); chk("R6 negative stride", rd_v, 64'hFFFF_FFFF_FFFF_FFFD);
        cr_write(2'd1, 64'd9);
        cr_read(2'd2, rd_v, "R6"); chk("R6 stride kept", rd_v, 64'hFFFF_FFFF_FFFF_FFFD);

        // R8: write collision, bulk wins; disjoint writes both land
        cr_write(2'd1, 64'(RL));
        sc_req = 1; sc_we = 1; sc_reg = 2'd0; sc_idx = 4'd5; sc_wdata = 64'h1111_1111_1111_1111;
        bk_we = 1; bk_reg = 2'd0; bk_idx = 4'd5; bk_wdata = 64'h2222_2222_2222_2222;
        @(negedge clk);
        sc_req = 0; sc_we = 0; bk_we = 0;
        model[0][5] = 64'h2222_2222_2222_2222;
        sc_access(0, 0, 5, 0); chk("R8 bulk wins", sc_rdata, model[0][5]);
        sc_req = 1; sc_we = 1; sc_reg = 2'd1; sc_idx = 4'd2; sc_wdata = 64'h3333_3333_3333_3333;
        bk_we = 1; bk_reg = 2'd2; bk_idx = 4'd2; bk_wdata = 64'h4444_4444_4444_4444;
        @(negedge clk);
        sc_req = 0; sc_we = 0; bk_we = 0;
        bk_read(1, 2, rd_v, "R8"); chk("R8 element write kept", rd_v, 64'h3333_3333_3333_3333);
        bk_read(2, 2, rd_v, "R8"); chk("R8 bulk write kept", rd_v, 64'h4444_4444_4444_4444);

        // R9: unused selector
        cr_write(2'd2, 64'd6);
        cr_write(2'd1, 64'd11);
        cr_write(2'd3, 64'd2);
        cr_read(2'd3, rd_v, "R9"); chk("R9 spare reads zero", rd_v, 64'd0);
        cr_read(2'd1, rd_v, "R9"); chk("R9 actlen kept", rd_v, 64'd11);
        cr_read(2'd2, rd_v, "R9"); chk("R9 stride kept", rd_v, 64'd6);
        cr_read(2'd0, rd_v, "R9"); chk("R9 maxlen kept", rd_v, 64'(RL));

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule